// File: doc/BRIEF.md
# Path Writeback Slot Selector

This block drives the writeback half of one Path ORAM access. Once the path that was just read sits in the stash, a start pulse hands the block the leaf ID of that path and the tree depth. The block then walks the same path from the leaf bucket up to the root, visiting the slots of each bucket in increasing slot order. It produces exactly one slot decision per clock cycle, with no gaps, so the length of a writeback is always levels × slots cycles. The block decides nothing else.

For each slot the block looks only at the top entry of an external, min-ordered candidate source (valid flag, leaf ID, stash index). If that candidate's leaf shares the path prefix down to the current level, the slot carries the candidate's stash index and a pop strobe is raised in the same cycle. The source must then present its next entry before the following clock edge. Otherwise the slot is marked dummy and nothing is popped: the source is ordered so that no other block could fit there either. Candidates that are never placed stay in the source and carry over to the next access. A one-cycle done pulse follows the root's last slot.

The state machine has three states. IDLE waits for start, and start taken in IDLE latches the configuration (transition IDLE→WALK). WALK emits one slot per cycle and leaves on the root's last slot (WALK→DONE). DONE raises done for one cycle and always returns to IDLE (DONE→IDLE). In WALK and DONE the start input is ignored.

Top module: `path_wb_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, wb_valid, wb_pop and done are 0.
- R2: A start taken in IDLE makes the first slot appear in the next cycle, with wb_level = levels−1 and wb_slot = 0.
- R3: Slots are emitted one per cycle with no gap. Within a level, wb_slot counts 0..SLOTS−1. The level then drops by one. The walk ends after exactly levels × SLOTS slot cycles, with level 0 and slot SLOTS−1 last.
- R4: Leaf IDs use bits levels−2 down to 0, with bit levels−2 selecting the branch below the root. A valid candidate fits level L (root = 0) when its leaf equals the latched path leaf in the L bits levels−2 down to levels−1−L. Level 0 always fits.
- R5: A slot whose candidate fits has wb_dummy = 0, wb_idx = cand_idx and wb_pop = 1 in the same cycle. A slot where it does not fit has wb_dummy = 1 and wb_pop = 0, and the source is left untouched.
- R6: When cand_valid is 0, every slot is a dummy and nothing is popped, even at the root.
- R7: done is high for exactly the one cycle after the last slot, with wb_valid = 0, and the block is back in IDLE in the cycle after that.
- R8: The path leaf and depth are latched at start. Changes to path_leaf or cfg_levels, and start pulses during WALK or DONE, have no effect on the current walk, and a start in DONE does not begin a new walk.
- R9: cfg_levels below 3 is treated as 3, and above MAX_LEVELS it is treated as MAX_LEVELS.
- R10: Leaf bits at positions levels−1 and above, in both path_leaf and cand_leaf, do not affect any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a writeback walk (taken only in IDLE) |
| cfg_levels | input | LVL_W (5) | Number of tree levels for this walk |
| path_leaf | input | LEAF_W (19) | Leaf ID of the path being written back |
| cand_valid | input | 1 | Candidate source has a top entry |
| cand_leaf | input | LEAF_W (19) | Assigned leaf of the top candidate |
| cand_idx | input | IDX_W (7) | Stash index of the top candidate |
| wb_valid | output | 1 | A slot decision is presented this cycle |
| wb_level | output | LVL_W (5) | Tree level of the slot (root = 0) |
| wb_slot | output | SLOT_W (2) | Slot number within the bucket |
| wb_dummy | output | 1 | Slot is filled with a dummy block |
| wb_idx | output | IDX_W (7) | Stash index of the placed block (0 for a dummy) |
| wb_pop | output | 1 | Remove the top candidate from the source |
| done | output | 1 | One-cycle pulse after the walk's last slot |

## Verification
The tightest coincidence is a placement on a bucket's last slot, which happens in the same cycle as the level step. The candidate the source advances to must then be judged against the next, shallower level, and never against the level just left. The bench provokes this with a directed walk that fills the leaf bucket exactly and follows with a candidate that fits only one level higher. Random walks also reach it with many candidates near the path. The bench judges every slot in sequence against its own prefix model with a bench-side queue, so a pop that is lost or doubled at the level step shows up as a wrong index or dummy flag from then on. A second coincidence, a start pulse arriving in the DONE cycle, is driven on every walk and must leave the block idle.

// File: rtl/path_wb_pkg.sv
package path_wb_pkg;

    localparam int MIN_LEVELS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } wb_state_e;

endpackage

// File: rtl/path_fit_check.sv
module path_fit_check #(
    parameter int LEAF_W = 19,
    parameter int LVL_W  = 5
) (
    input  logic [LEAF_W-1:0] diff,
    input  logic [LVL_W-1:0]  span,
    input  logic [LVL_W-1:0]  level,
    output logic              fit
);
    logic [LVL_W-1:0]  lo;
    logic [LEAF_W-1:0] mask;

    assign lo = span - level;

    for (genvar b = 0; b < LEAF_W; b++) begin : g_mask
        assign mask[b] = (LVL_W'(b) < span) && (LVL_W'(b) >= lo);
    end

    assign fit = ~|(diff & mask);
endmodule

// File: rtl/path_walk_counter.sv
module path_walk_counter #(
    parameter int LVL_W  = 5,
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LVL_W-1:0]  load_level,
    output logic [LVL_W-1:0]  level,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            slot  <= '0;
        end else if (load) begin
            level <= load_level;
            slot  <= '0;
        end else if (step) begin
            if (slot == LAST_SLOT) begin
                slot  <= '0;
                level <= level - 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    assign last = (level == '0) && (slot == LAST_SLOT);
endmodule

// File: rtl/path_wb_selector.sv
module path_wb_selector
    import path_wb_pkg::*;
#(
    parameter int MAX_LEVELS = 20,
    parameter int SLOTS      = 4,
    parameter int STASH      = 128,
    parameter int LEAF_W     = MAX_LEVELS - 1,
    parameter int LVL_W      = $clog2(MAX_LEVELS + 1),
    parameter int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int IDX_W      = $clog2(STASH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LVL_W-1:0]  cfg_levels,
    input  logic [LEAF_W-1:0] path_leaf,
    input  logic              cand_valid,
    input  logic [LEAF_W-1:0] cand_leaf,
    input  logic [IDX_W-1:0]  cand_idx,
    output logic              wb_valid,
    output logic [LVL_W-1:0]  wb_level,
    output logic [SLOT_W-1:0] wb_slot,
    output logic              wb_dummy,
    output logic [IDX_W-1:0]  wb_idx,
    output logic              wb_pop,
    output logic              done
);
    localparam logic [LVL_W-1:0] LV_MIN = LVL_W'(MIN_LEVELS);
    localparam logic [LVL_W-1:0] LV_MAX = LVL_W'(MAX_LEVELS);

    wb_state_e         state, state_nx;
    logic [LVL_W-1:0]  lv_clamped;
    logic [LVL_W-1:0]  span_q;
    logic [LEAF_W-1:0] path_q;
    logic              load, step, last, fit, placed;
    logic [LVL_W-1:0]  cur_level;
    logic [SLOT_W-1:0] cur_slot;

    // R9: depth clamp
    always_comb begin
        if (cfg_levels < LV_MIN)      lv_clamped = LV_MIN;
        else if (cfg_levels > LV_MAX) lv_clamped = LV_MAX;
        else                          lv_clamped = cfg_levels;
    end

    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_WALK);

    // R8: configuration latched only when a walk begins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
            path_q <= '0;
        end else if (load) begin
            span_q <= lv_clamped - 1'b1;
            path_q <= path_leaf;
        end
    end

    path_walk_counter #(
        .LVL_W (LVL_W),
        .SLOTS (SLOTS),
        .SLOT_W(SLOT_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .load_level(lv_clamped - 1'b1),
        .level     (cur_level),
        .slot      (cur_slot),
        .last      (last)
    );

    path_fit_check #(
        .LEAF_W(LEAF_W),
        .LVL_W (LVL_W)
    ) u_fit (
        .diff (cand_leaf ^ path_q),
        .span (span_q),
        .level(cur_level),
        .fit  (fit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_WALK;
            ST_WALK: if (last)  state_nx = ST_DONE;
            ST_DONE:            state_nx = ST_IDLE;
            default:            state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        placed   = 1'b0;
        wb_valid = 1'b0;
        wb_dummy = 1'b0;
        wb_idx   = '0;
        done     = 1'b0;
        wb_level = cur_level;
        wb_slot  = cur_slot;
        unique case (state)
            ST_IDLE: ;
            ST_WALK: begin
                wb_valid = 1'b1;
                placed   = cand_valid && fit;
                wb_dummy = !placed;
                wb_idx   = placed ? cand_idx : '0;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        wb_pop = placed;
    end
endmodule

// File: rtl/path_wb_selector_chk.sv
module path_wb_selector_chk #(
    parameter int SLOTS  = 4,
    parameter int LVL_W  = 5,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cand_valid,
    input logic              wb_valid,
    input logic [LVL_W-1:0]  wb_level,
    input logic [SLOT_W-1:0] wb_slot,
    input logic              wb_dummy,
    input logic              wb_pop,
    input logic              done
);
    // R6: nothing popped without a candidate
    p_pop_needs_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pop |-> cand_valid);

    // R4: the root accepts any valid candidate
    p_root_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_level == '0 && cand_valid) |-> !wb_dummy);

    // R2: a walk begins at slot 0
    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> wb_slot == '0);

    // R3: slot advance within a bucket
    p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid) && $past(wb_slot) != SLOT_W'(SLOTS - 1))
        |-> (wb_slot == $past(wb_slot) + 1'b1 && wb_level == $past(wb_level)));

    // R3: level step at a bucket boundary
    p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid) && $past(wb_slot) == SLOT_W'(SLOTS - 1))
        |-> (wb_slot == '0 && wb_level == $past(wb_level) - 1'b1));

    // R7: done only right after the root's last slot
    p_done_after_root_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wb_valid) && $past(wb_level) == '0
                  && $past(wb_slot) == SLOT_W'(SLOTS - 1)));

    // R7: done is a single-cycle pulse, never alongside a slot
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !wb_valid));
endmodule

bind path_wb_selector path_wb_selector_chk #(
    .SLOTS (SLOTS),
    .LVL_W (LVL_W),
    .SLOT_W(SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_valid(cand_valid),
    .wb_valid  (wb_valid),
    .wb_level  (wb_level),
    .wb_slot   (wb_slot),
    .wb_dummy  (wb_dummy),
    .wb_pop    (wb_pop),
    .done      (done)
);

// File: tb/test_path_wb_selector.sv
`timescale 1ns/1ps
module test_path_wb_selector;
    localparam int MAXL   = 20;
    localparam int SLOTS  = 4;
    localparam int LEAF_W = MAXL - 1;
    localparam int LVL_W  = 5;
    localparam int SLOT_W = 2;
    localparam int IDX_W  = 7;
    localparam int QN     = 96;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LVL_W-1:0]  cfg_levels = '0;
    logic [LEAF_W-1:0] path_leaf = '0;
    logic              cand_valid = 1'b0;
    logic [LEAF_W-1:0] cand_leaf = '0;
    logic [IDX_W-1:0]  cand_idx = '0;
    logic              wb_valid, wb_dummy, wb_pop, done;
    logic [LVL_W-1:0]  wb_level;
    logic [SLOT_W-1:0] wb_slot;
    logic [IDX_W-1:0]  wb_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [LEAF_W-1:0] q_leaf [QN];
    logic [IDX_W-1:0]  q_idx  [QN];
    int q_n, q_head;

    always #10 clk = ~clk;

    path_wb_selector i_path_wb_selector (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_levels(cfg_levels),
        .path_leaf(path_leaf), .cand_valid(cand_valid), .cand_leaf(cand_leaf),
        .cand_idx(cand_idx), .wb_valid(wb_valid), .wb_level(wb_level),
        .wb_slot(wb_slot), .wb_dummy(wb_dummy), .wb_idx(wb_idx),
        .wb_pop(wb_pop), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_lv(input int v);
        if (v < 3) return 3;
        if (v > MAXL) return MAXL;
        return v;
    endfunction

    // prefix match bit by bit from the root branch downward
    function automatic bit fits(input logic [LEAF_W-1:0] leaf,
                                input logic [LEAF_W-1:0] path,
                                input int lv, input int lvl);
        for (int b = 0; b < lvl; b++) begin
            if (leaf[lv - 2 - b] != path[lv - 2 - b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic present;
        cand_valid = (q_head < q_n);
        cand_leaf  = (q_head < q_n) ? q_leaf[q_head] : LEAF_W'($urandom);
        cand_idx   = (q_head < q_n) ? q_idx[q_head]  : IDX_W'($urandom);
    endtask

    // one full writeback; starts and ends at a negedge
    task automatic walk(input int cfg, input logic [LEAF_W-1:0] path);
        int lv;
        bit exp_place;
        lv = clamp_lv(cfg);
        q_head = 0;
        present();
        cfg_levels = LVL_W'(cfg);
        path_leaf  = path;
        start      = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < lv * SLOTS; k++) begin
            if (k > 0) @(negedge clk);
            exp_place = (q_head < q_n) &&
                        fits(q_leaf[q_head], path, lv, lv - 1 - k / SLOTS);
            if (k == 0)
                chk(wb_level == LVL_W'(lv - 1) && wb_slot == 0, "R2", "first level",
                    wb_level, lv - 1);
            chk(wb_valid == 1'b1, "R3", "valid in walk", wb_valid, 1);
            chk(wb_level == LVL_W'(lv - 1 - k / SLOTS), "R3", "level", wb_level,
                lv - 1 - k / SLOTS);
            chk(wb_slot == SLOT_W'(k % SLOTS), "R3", "slot", wb_slot, k % SLOTS);
            if (q_head >= q_n)
                chk(wb_dummy && !wb_pop, "R6", "empty source dummy", wb_dummy, 1);
            else
                chk(wb_dummy == !exp_place, "R4", "fit decision", wb_dummy, !exp_place);
            chk(wb_pop == exp_place, "R5", "pop", wb_pop, exp_place);
            if (exp_place)
                chk(wb_idx == q_idx[q_head], "R5", "index", wb_idx, q_idx[q_head]);
            // R8: disturb inputs mid-walk
            if (k == 1) begin
                start      = 1'b1;
                path_leaf  = ~path;
                cfg_levels = LVL_W'($urandom_range(0, 31));
            end
            if (k == 2) start = 1'b0;
            @(posedge clk);
            #1;
            if (exp_place) q_head++;
            present();
        end
        @(negedge clk);
        chk(done == 1'b1 && wb_valid == 1'b0, "R7", "done pulse", done, 1);
        start = 1'b1;   // R8: start during DONE must be ignored
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7", "done single cycle", done, 0);
        chk(wb_valid == 1'b0, "R8", "no walk from DONE start", wb_valid, 0);
        @(negedge clk);
        chk(wb_valid == 1'b0 && wb_pop == 1'b0, "R7", "idle after done", wb_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lv;
        logic [LEAF_W-1:0] p;
        void'($urandom(32'h5EED_0A11));
        q_n = 0;
        q_head = 0;
        cand_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!wb_valid && !wb_pop && !done, "R1", "outputs in reset", wb_pop, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wb_valid && !wb_pop && !done, "R1", "outputs after reset", wb_valid, 0);

        // R3 R4: leaf bucket filled exactly, next fits one level up
        q_n = 6;
        for (int i = 0; i < 4; i++) begin q_leaf[i] = '0; q_idx[i] = IDX_W'(10 + i); end
        q_leaf[4] = LEAF_W'(1);  q_idx[4] = 7'd20;   // fits level 2 of 4
        q_leaf[5] = LEAF_W'(4);  q_idx[5] = 7'd21;   // fits level 0 only
        walk(4, '0);

        // R9: depth below range clamps to 3; all candidates match the path
        q_n = 14;
        for (int i = 0; i < 14; i++) begin q_leaf[i] = LEAF_W'(2); q_idx[i] = IDX_W'(i); end
        walk(1, LEAF_W'(2));

        // R6 R9: depth above range clamps to MAX, empty source
        q_n = 0;
        walk(31, LEAF_W'($urandom));

        // R4: candidate fits only at the root
        p = LEAF_W'($urandom);
        q_n = 1; q_leaf[0] = p ^ LEAF_W'(1 << 8); q_idx[0] = 7'd99;
        walk(10, p);

        // random walks; R10 via garbage upper leaf bits
        for (int w = 0; w < 40; w++) begin
            lv = $urandom_range(3, MAXL);
            p  = LEAF_W'($urandom);
            q_n = $urandom_range(0, 24);
            for (int i = 0; i < q_n; i++) begin
                int sh;
                logic [LEAF_W-1:0] m;
                sh = $urandom_range(0, lv - 1);
                m  = LEAF_W'((32'h1 << sh) - 1);
                q_leaf[i] = (p ^ (LEAF_W'($urandom) & m)) ^
                            (LEAF_W'($urandom) & ~LEAF_W'((32'h1 << (lv - 1)) - 1));
                q_idx[i]  = IDX_W'($urandom);
            end
            walk(lv, p);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule